// File: doc/BRIEF.md
# SCSI Host Adapter Bus-Master DMA Engine

This block is the DMA control section of a SCSI host adapter that sits on a PCI bus. Software programs a set of "start" shadow registers and then writes a command word. The start command copies the shadow values into working counters and arms the engine. The SCSI protocol core then asks for bursts in either direction. The engine splits each burst into word beats on a simple request/acknowledge memory port. Each beat carries byte enables. The working count and address advance beat by beat, and the done flag rises when the count runs out.

Software reads status through the same register port. Error, abort and done can be cleared in one of two ways, chosen by a bus-control level input. In one mode software writes a one to each bit it wants to clear. In the other mode the bits clear as a side effect of reading status. The SCSI core's pending interrupt shows up in status reads only; it is never stored. A burst whose direction disagrees with the command's direction bit is dropped, and so is any burst that arrives while the engine is disabled. A dropped burst leaves the counters untouched.

Top module: `sdma_engine`

## Requirements
- R1: After reset, index 0 (command) reads 0, index 3 (working count) reads 0, index 4 (working address) reads 0xFFFFFFFF, index 7 (working list address) reads 0xFFFFFFFD, and index 5 (status) reads 0.
- R2: Indexes 1 (start count), 2 (start address) and 6 (start list address) hold what is written to them. Writes to indexes 3, 4 and 7 have no effect.
- R3: Bits [1:0] of a command write select an action. 3 (start) raises `dmaEnable` and 0 (idle) lowers it. 2 (abort) pulses `abortReq` high for exactly one cycle. 1 (blast) changes neither output.
- R4: A start command loads index 3 from index 1, index 4 from index 2 and index 7 from index 6, and clears status bits [5:0].
- R5: An accepted burst is clamped to the smaller of `xferLen` and the working count. It is issued as beats to word-aligned `memAddr`. Each beat's `memBe` covers the lanes from the address offset up to the word end or the end of the burst. One beat completes per cycle in which `memReq` and `memAck` are both high. Each completed beat lowers the working count and raises the working address by the number of bytes moved.
- R6: The burst ends with a one-cycle `xferDone` pulse. When the working count reaches zero, status bit 3 (done) is set.
- R7: Command bit 7 gives the direction: 1 means device-to-memory, which drives `memWrite` high. A request whose `xferDirIn` differs from bit 7 is dropped, and so is any request made while `dmaEnable` is low. A dropped request produces no beat, leaves the count unchanged, and still pulses `xferDone`.
- R8: With `w1cMode` high, a write to status clears each of bits 1 (error), 2 (abort) and 3 (done) where the write data has a one. Reads do not clear.
- R9: With `w1cMode` low, writes to status are ignored. A status read returns the current value and then clears bits 1, 2 and 3.
- R10: A status read shows bit 4 set whenever `scsiIrq` is high. The bit is not kept once `scsiIrq` falls.
- R11: A `cmdComplete` pulse forces the working count to zero and sets done.
- R12: Device-to-memory beats carry `coreWData` on `memWData`. On memory-to-device beats, `coreRValid` is high and `coreRData` carries `memRData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects) |
| regIdx | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regIdx` |
| w1cMode | input | 1 | Status clear policy: 1 write-one-to-clear, 0 clear-on-read |
| scsiIrq | input | 1 | SCSI core interrupt pending |
| cmdComplete | input | 1 | SCSI command finished pulse |
| xferStart | input | 1 | Burst request from SCSI core |
| xferDirIn | input | 1 | Requested direction, 1 device-to-memory |
| xferLen | input | 16 | Requested burst length in bytes |
| xferBusy | output | 1 | Burst in progress |
| xferDone | output | 1 | Burst finished or dropped pulse |
| coreWData | input | 32 | Lane-aligned data from SCSI core |
| coreRData | output | 32 | Data toward SCSI core |
| coreRValid | output | 1 | `coreRData` valid this cycle |
| memReq | output | 1 | Memory beat request |
| memWrite | output | 1 | Beat writes memory |
| memAddr | output | 32 | Word-aligned beat address |
| memBe | output | 4 | Beat byte enables |
| memWData | output | 32 | Beat write data |
| memAck | input | 1 | Beat accepted |
| memRData | input | 32 | Beat read data |
| dmaEnable | output | 1 | DMA armed |
| abortReq | output | 1 | Cancel active request pulse |

## Verification
A working count that is off by even one byte shows up first in the final beat's byte enables. The burst then ends one beat early or one beat late, and `xferDone` moves away from its expected cycle. A wrong working address shows on `memAddr` and `memBe` at the very next beat. Errors in status state hide until the next status read. That read exposes them at once, and a second read shows whether the clear policy matched `w1cMode`. A dropped-direction burst that slips through is visible in the cycle after the request as a raised `memReq`.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam logic [2:0] IX_CMD   = 3'd0;
  localparam logic [2:0] IX_SCNT  = 3'd1;
  localparam logic [2:0] IX_SADR  = 3'd2;
  localparam logic [2:0] IX_WCNT  = 3'd3;
  localparam logic [2:0] IX_WADR  = 3'd4;
  localparam logic [2:0] IX_STAT  = 3'd5;
  localparam logic [2:0] IX_SLST  = 3'd6;
  localparam logic [2:0] IX_WLST  = 3'd7;

  localparam logic [1:0] ACT_IDLE  = 2'd0;
  localparam logic [1:0] ACT_BLAST = 2'd1;
  localparam logic [1:0] ACT_ABORT = 2'd2;
  localparam logic [1:0] ACT_START = 2'd3;

  localparam int STAT_W    = 6;
  localparam int DIR_BIT   = 7;
  localparam int DONE_BIT  = 3;
  localparam int IRQ_BIT   = 4;
  localparam logic [STAT_W-1:0] CLR_MASK = 6'b001110;

  typedef enum logic {ST_IDLE, ST_BURST} xferState_t;

  typedef struct packed {
    logic wrCmd;
    logic wrStartCnt;
    logic wrStartAdr;
    logic wrStartLst;
    logic start;
    logic statWr1c;
    logic statRdClr;
    logic beat;
    logic forceZero;
  } dpStrobe_t;
endpackage

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int LEN_W     = 16,
  parameter int BUS_BYTES = 4,
  localparam int OFF_W    = $clog2(BUS_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [2:0]           regIdx,
  input  logic [1:0]           cmdCode,
  input  logic                 w1cMode,
  input  logic                 cmdComplete,
  input  logic                 xferStart,
  input  logic                 xferDirIn,
  input  logic [LEN_W-1:0]     xferLen,
  input  logic                 cmdDir,
  input  logic [REG_W-1:0]     wkCount,
  input  logic [OFF_W-1:0]     wkOff,
  input  logic                 memAck,
  output dpStrobe_t            strobe,
  output logic [REG_W-1:0]     beatBytes,
  output logic                 memReq,
  output logic [BUS_BYTES-1:0] memBe,
  output logic                 dmaEnable,
  output logic                 abortReq,
  output logic                 xferBusy,
  output logic                 xferDone
);
  xferState_t state;
  logic [REG_W-1:0] burstLeft;
  logic [REG_W-1:0] room;
  logic [REG_W-1:0] offExt;
  logic [REG_W-1:0] clampLen;
  logic             cmdWr;
  logic             accept;

  assign cmdWr    = regWrEn && (regIdx == IX_CMD);
  assign clampLen = (REG_W'(xferLen) < wkCount) ? REG_W'(xferLen) : wkCount;
  assign accept   = dmaEnable && (xferDirIn == cmdDir) && (clampLen != '0);

  assign offExt    = REG_W'(wkOff);
  assign room      = REG_W'(BUS_BYTES) - offExt;
  assign beatBytes = (burstLeft < room) ? burstLeft : room;
  assign memReq    = (state == ST_BURST) && (wkCount != '0);
  assign xferBusy  = (state == ST_BURST);

  always_comb begin
    for (int i = 0; i < BUS_BYTES; i++) begin
      memBe[i] = memReq && (REG_W'(i) >= offExt) && (REG_W'(i) < offExt + beatBytes);
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.wrCmd      = cmdWr;
    strobe.start      = cmdWr && (cmdCode == ACT_START);
    strobe.wrStartCnt = regWrEn && (regIdx == IX_SCNT);
    strobe.wrStartAdr = regWrEn && (regIdx == IX_SADR);
    strobe.wrStartLst = regWrEn && (regIdx == IX_SLST);
    strobe.statWr1c   = regWrEn && (regIdx == IX_STAT) && w1cMode;
    strobe.statRdClr  = regRdEn && (regIdx == IX_STAT) && !w1cMode;
    strobe.beat       = memReq && memAck;
    strobe.forceZero  = cmdComplete;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      burstLeft <= '0;
      dmaEnable <= 1'b0;
      abortReq  <= 1'b0;
      xferDone  <= 1'b0;
    end else begin
      abortReq <= cmdWr && (cmdCode == ACT_ABORT);
      xferDone <= 1'b0;
      if (cmdWr && (cmdCode == ACT_START)) dmaEnable <= 1'b1;
      if (cmdWr && (cmdCode == ACT_IDLE))  dmaEnable <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (xferStart) begin
            if (accept) begin
              burstLeft <= clampLen;
              state     <= ST_BURST;
            end else begin
              xferDone <= 1'b1;
            end
          end
        end
        default: begin
          if (wkCount == '0) begin
            state    <= ST_IDLE;
            xferDone <= 1'b1;
          end else if (memAck) begin
            burstLeft <= burstLeft - beatBytes;
            if (burstLeft == beatBytes) begin
              state    <= ST_IDLE;
              xferDone <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdma_datapath.sv
module sdma_datapath
  import sdma_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [REG_W-1:0] beatBytes,
  input  logic [2:0]       regIdx,
  input  logic [REG_W-1:0] regWrData,
  input  logic             scsiIrq,
  output logic [REG_W-1:0] regRdData,
  output logic [REG_W-1:0] wkCount,
  output logic [REG_W-1:0] wkAddr,
  output logic             cmdDir
);
  localparam logic [REG_W-1:0] WADR_RST = '1;
  localparam logic [REG_W-1:0] WLST_RST = ~REG_W'(2);

  logic [REG_W-1:0]  cmdReg, startCnt, startAdr, startLst, wkLst;
  logic [STAT_W-1:0] statReg, statClr, statSet, statView;

  assign cmdDir = cmdReg[DIR_BIT];

  always_comb begin
    statClr = '0;
    if (strobe.statWr1c)  statClr = regWrData[STAT_W-1:0] & CLR_MASK;
    if (strobe.statRdClr) statClr = CLR_MASK;
    statSet = '0;
    if ((strobe.beat && (wkCount == beatBytes)) || strobe.forceZero) statSet[DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      startCnt <= '0;
      startAdr <= '0;
      startLst <= '0;
      wkCount  <= '0;
      wkAddr   <= WADR_RST;
      wkLst    <= WLST_RST;
      statReg  <= '0;
    end else begin
      if (strobe.wrCmd)      cmdReg   <= regWrData;
      if (strobe.wrStartCnt) startCnt <= regWrData;
      if (strobe.wrStartAdr) startAdr <= regWrData;
      if (strobe.wrStartLst) startLst <= regWrData;
      if (strobe.start) begin
        wkCount <= startCnt;
        wkAddr  <= startAdr;
        wkLst   <= startLst;
        statReg <= '0;
      end else begin
        if (strobe.forceZero)  wkCount <= '0;
        else if (strobe.beat)  wkCount <= wkCount - beatBytes;
        if (strobe.beat)       wkAddr  <= wkAddr + beatBytes;
        statReg <= (statReg & ~statClr) | statSet;
      end
    end
  end

  always_comb begin
    statView          = statReg;
    statView[IRQ_BIT] = statReg[IRQ_BIT] | scsiIrq;
    case (regIdx)
      IX_CMD:  regRdData = cmdReg;
      IX_SCNT: regRdData = startCnt;
      IX_SADR: regRdData = startAdr;
      IX_WCNT: regRdData = wkCount;
      IX_WADR: regRdData = wkAddr;
      IX_STAT: regRdData = REG_W'(statView);
      IX_SLST: regRdData = startLst;
      default: regRdData = wkLst;
    endcase
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int LEN_W     = 16,
  parameter int BUS_BYTES = 4,
  localparam int OFF_W    = $clog2(BUS_BYTES),
  localparam int BUS_W    = BUS_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [2:0]           regIdx,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 w1cMode,
  input  logic                 scsiIrq,
  input  logic                 cmdComplete,
  input  logic                 xferStart,
  input  logic                 xferDirIn,
  input  logic [LEN_W-1:0]     xferLen,
  output logic                 xferBusy,
  output logic                 xferDone,
  input  logic [BUS_W-1:0]     coreWData,
  output logic [BUS_W-1:0]     coreRData,
  output logic                 coreRValid,
  output logic                 memReq,
  output logic                 memWrite,
  output logic [REG_W-1:0]     memAddr,
  output logic [BUS_BYTES-1:0] memBe,
  output logic [BUS_W-1:0]     memWData,
  input  logic                 memAck,
  input  logic [BUS_W-1:0]     memRData,
  output logic                 dmaEnable,
  output logic                 abortReq
);
  dpStrobe_t        strobe;
  logic [REG_W-1:0] beatBytes;
  logic [REG_W-1:0] wkCount;
  logic [REG_W-1:0] wkAddr;
  logic             cmdDir;
  logic [1:0]       cmdCode;

  assign cmdCode    = regWrData[1:0];
  assign memWrite   = cmdDir;
  assign memWData   = coreWData;
  assign coreRData  = memRData;
  assign coreRValid = memReq && memAck && !cmdDir;
  assign memAddr    = {wkAddr[REG_W-1:OFF_W], {OFF_W{1'b0}}};

  sdma_ctrl #(.REG_W(REG_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regIdx(regIdx),
    .cmdCode(cmdCode), .w1cMode(w1cMode), .cmdComplete(cmdComplete),
    .xferStart(xferStart), .xferDirIn(xferDirIn), .xferLen(xferLen),
    .cmdDir(cmdDir), .wkCount(wkCount), .wkOff(wkAddr[OFF_W-1:0]), .memAck(memAck),
    .strobe(strobe), .beatBytes(beatBytes), .memReq(memReq), .memBe(memBe),
    .dmaEnable(dmaEnable), .abortReq(abortReq), .xferBusy(xferBusy), .xferDone(xferDone)
  );

  sdma_datapath #(.REG_W(REG_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatBytes(beatBytes), .regIdx(regIdx),
    .regWrData(regWrData), .scsiIrq(scsiIrq), .regRdData(regRdData),
    .wkCount(wkCount), .wkAddr(wkAddr), .cmdDir(cmdDir)
  );
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int REG_W     = 32,
  parameter int BUS_BYTES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [2:0]           regIdx,
  input logic [1:0]           cmdCode,
  input logic                 memReq,
  input logic                 memAck,
  input logic [BUS_BYTES-1:0] memBe,
  input logic [REG_W-1:0]     wkCount,
  input logic [REG_W-1:0]     wkAddr,
  input logic                 cmdComplete,
  input logic                 dmaEnable,
  input logic                 xferStart,
  input logic                 xferDirIn,
  input logic                 xferBusy,
  input logic                 cmdDir
);
  logic cmdWr;
  assign cmdWr = regWrEn && (regIdx == 3'd0);

  AST_BEAT_HAS_LANES: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBe != '0)); // R5

  AST_COUNT_DECREMENTS: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !cmdComplete && !cmdWr)
      |=> (wkCount == $past(wkCount) - REG_W'($countones($past(memBe))))); // R5

  AST_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !cmdWr)
      |=> (wkAddr == $past(wkAddr) + REG_W'($countones($past(memBe))))); // R5

  AST_MISMATCH_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && !xferBusy && (xferDirIn != cmdDir)) |=> !memReq); // R7

  AST_COMPLETE_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdComplete && !cmdWr) |=> (wkCount == '0)); // R11

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (cmdCode == 2'b11)) |=> dmaEnable); // R3
endmodule

bind sdma_engine sdma_engine_chk #(.REG_W(REG_W), .BUS_BYTES(BUS_BYTES)) chk (.*);

// File: tb/sdma_engine_test.sv
module sdma_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 0, regRdEn = 0;
  logic [2:0]  regIdx = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic        w1cMode = 0, scsiIrq = 0, cmdComplete = 0;
  logic        xferStart = 0, xferDirIn = 0;
  logic [15:0] xferLen = 0;
  logic        xferBusy, xferDone;
  logic [31:0] coreWData = 32'hA5A5_5A5A, coreRData;
  logic        coreRValid;
  logic        memReq, memWrite, memAck = 0;
  logic [31:0] memAddr, memWData, memRData = 32'h0BAD_F00D;
  logic [3:0]  memBe;
  logic        dmaEnable, abortReq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdma_engine uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regIdx = idx; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rdReg(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk); regRdEn = 1; regIdx = idx; #1 v = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic expectReg(input logic [2:0] idx, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rdReg(idx, v);
    check(v == exp, req, $sformatf("reg%0d", idx), v, exp);
  endtask

  task automatic runBurst(input bit dirIn, input int len, input int addr0, input int cnt0,
                          input bit stall, input bit drop, input string req);
    int a = addr0, left, off, n;
    bit tog = 0, sawDone = 0;
    left = drop ? 0 : ((len < cnt0) ? len : cnt0);
    @(negedge clk); xferStart = 1; xferDirIn = dirIn; xferLen = 16'(len);
    @(negedge clk); xferStart = 0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      memAck = stall ? tog : 1'b1;
      #1;
      if (xferDone) begin sawDone = 1; break; end
      if (memReq && memAck) begin
        off = a % 4;
        n = (4 - off < left) ? 4 - off : left;
        check(memAddr == 32'(a - off), req, "memAddr", memAddr, 32'(a - off));
        check(memBe == 4'(((1 << n) - 1) << off), req, "memBe", 32'(memBe), 32'(((1 << n) - 1) << off));
        check(memWrite == dirIn, req, "memWrite", 32'(memWrite), 32'(dirIn));
        if (dirIn) check(memWData == coreWData, "R12", "memWData", memWData, coreWData);
        else check(coreRValid && coreRData == memRData, "R12", "coreRData", coreRData, memRData);
        a += n; left -= n;
      end else if (drop) begin
        check(!memReq, "R7", "memReq on dropped", 32'(memReq), 0);
      end
      @(negedge clk); tog = !tog;
    end
    memAck = 0;
    check(sawDone, "R6", "xferDone pulse", 32'(sawDone), 1);
    check(left == 0, req, "bytes left", 32'(left), 0);
    @(negedge clk);
    check(!xferDone, "R6", "xferDone one cycle", 32'(xferDone), 0);
  endtask

  task automatic testReset();
    expectReg(3'd0, 32'h0, "R1");
    expectReg(3'd3, 32'h0, "R1");
    expectReg(3'd4, 32'hFFFF_FFFF, "R1");
    expectReg(3'd7, 32'hFFFF_FFFD, "R1");
    expectReg(3'd5, 32'h0, "R1");
    check(!dmaEnable && !memReq, "R1", "outputs idle", 32'({dmaEnable, memReq}), 0);
  endtask

  task automatic testShadow();
    wrReg(3'd1, 32'h0000_0010);
    wrReg(3'd2, 32'h0000_1002);
    wrReg(3'd6, 32'h0000_0ABC);
    wrReg(3'd3, 32'h1234_5678);
    wrReg(3'd4, 32'h1234_5678);
    wrReg(3'd7, 32'h1234_5678);
    expectReg(3'd1, 32'h10, "R2");
    expectReg(3'd2, 32'h1002, "R2");
    expectReg(3'd6, 32'hABC, "R2");
    expectReg(3'd3, 32'h0, "R2");
    expectReg(3'd4, 32'hFFFF_FFFF, "R2");
    expectReg(3'd7, 32'hFFFF_FFFD, "R2");
  endtask

  task automatic testStart();
    wrReg(3'd0, 32'h83);
    check(dmaEnable, "R3", "dmaEnable after start", 32'(dmaEnable), 1);
    expectReg(3'd3, 32'h10, "R4");
    expectReg(3'd4, 32'h1002, "R4");
    expectReg(3'd7, 32'hABC, "R4");
  endtask

  task automatic testBursts();
    runBurst(1'b1, 7, 32'h1002, 16, 1'b0, 1'b0, "R5");
    expectReg(3'd3, 32'd9, "R5");
    expectReg(3'd4, 32'h1009, "R5");
    runBurst(1'b1, 20, 32'h1009, 9, 1'b1, 1'b0, "R5");
    expectReg(3'd3, 32'd0, "R5");
    expectReg(3'd4, 32'h1012, "R5");
    expectReg(3'd5, 32'h08, "R6");
    expectReg(3'd5, 32'h00, "R9");
  endtask

  task automatic testDirection();
    wrReg(3'd1, 32'd8);
    wrReg(3'd2, 32'h2000);
    wrReg(3'd0, 32'h03);
    runBurst(1'b1, 4, 32'h2000, 8, 1'b0, 1'b1, "R7");
    expectReg(3'd3, 32'd8, "R7");
    runBurst(1'b0, 4, 32'h2000, 8, 1'b0, 1'b0, "R12");
    expectReg(3'd3, 32'd4, "R12");
  endtask

  task automatic testCommands();
    wrReg(3'd0, 32'h01);
    check(dmaEnable && !abortReq, "R3", "blast no effect", 32'({dmaEnable, abortReq}), 32'h2);
    wrReg(3'd0, 32'h02);
    #1 check(abortReq, "R3", "abort pulse", 32'(abortReq), 1);
    @(negedge clk); #1 check(!abortReq, "R3", "abort one cycle", 32'(abortReq), 0);
    wrReg(3'd0, 32'h00);
    check(!dmaEnable, "R3", "idle disables", 32'(dmaEnable), 0);
    runBurst(1'b0, 4, 32'h2004, 4, 1'b0, 1'b1, "R7");
    expectReg(3'd3, 32'd4, "R7");
  endtask

  task automatic testStatus();
    w1cMode = 1;
    @(negedge clk); cmdComplete = 1;
    @(negedge clk); cmdComplete = 0;
    expectReg(3'd3, 32'd0, "R11");
    expectReg(3'd5, 32'h08, "R11");
    expectReg(3'd5, 32'h08, "R8");
    wrReg(3'd5, 32'h04);
    expectReg(3'd5, 32'h08, "R8");
    wrReg(3'd5, 32'h08);
    expectReg(3'd5, 32'h00, "R8");
    w1cMode = 0;
    @(negedge clk); cmdComplete = 1;
    @(negedge clk); cmdComplete = 0;
    wrReg(3'd5, 32'h0E);
    expectReg(3'd5, 32'h08, "R9");
    expectReg(3'd5, 32'h00, "R9");
    scsiIrq = 1;
    expectReg(3'd5, 32'h10, "R10");
    scsiIrq = 0;
    expectReg(3'd5, 32'h00, "R10");
    w1cMode = 1;
    @(negedge clk); cmdComplete = 1;
    @(negedge clk); cmdComplete = 0;
    wrReg(3'd0, 32'h83);
    expectReg(3'd5, 32'h00, "R4");
    w1cMode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testShadow();
    testStart();
    testBursts();
    testDirection();
    testCommands();
    testStatus();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule